// File: doc/BRIEF.md
# Multi-Word Write Admission Checker

This block belongs to the command-execution path of a passive UHF tag controller. It receives a write request that has already been decoded and authenticated upstream. The request names a memory bank, a starting word pointer, a word count and up to two data words. The block decides whether the request may proceed. If it may, the block issues one or two word writes on a simple memory port. If it may not, it reports an error byte, or it stays silent when the request asks for zero words.

The block also holds the permanent write locks for user memory. User memory is split into two blocks of two words each. Those locks take effect only while the configuration input selects the wide 64-bit user profile. In the narrow profile, requests to set them are discarded. Every decision is reported as a single-cycle outcome pulse. While a write sequence is running, a busy flag stays high and new requests are not taken.

Top module: `mw_write_gate`

## Requirements
- R1: A request with count 1 is accepted: outcome ACCEPT (code 01), and exactly one write of `req_wdata[15:0]` to the requested bank and pointer.
- R2: A request with count 2 and an even pointer is accepted. It is carried out as two writes on consecutive cycles: first `req_wdata[15:0]` to the pointer, then `req_wdata[31:16]` to pointer+1. Busy stays high during both.
- R3: A request with count 2 and an odd pointer yields outcome ERROR (code 10) with error byte 0x00, and no write.
- R4: A request with count greater than 2 yields outcome ERROR with error byte 0x00, and no write.
- R5: A request with count 0 yields outcome SILENT (code 11), with error byte 0x00 and no write.
- R6: With `user_wide` high, a lock request permanently locks each block whose mask bit is set. Block 0 covers user words 0–1 and block 1 covers words 2–3; user memory is bank 2'b11. A later write that would touch any word of a locked block yields ERROR with byte 0x04 and no write. Writes elsewhere are unaffected.
- R7: With `user_wide` low, a lock request changes nothing, so writes to user words 0–3 remain accepted afterwards.
- R8: The outcome appears on `resp_valid` for exactly one cycle, in the cycle after the request is sampled. The first write of an accepted request appears in that same cycle.
- R9: A request presented while busy is high is discarded: it produces no outcome and no write.
- R10: After reset, there is no outcome pulse and no write, busy is low, and no user block is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present this cycle |
| req_bank | input | 2 | Target memory bank (2'b11 = user) |
| req_ptr | input | PTR_W | Starting word pointer |
| req_count | input | CNT_W | Number of words requested |
| req_wdata | input | 2*WORD_W | Data; low half is the first word |
| user_wide | input | 1 | 1 = 64-bit user profile, 0 = 32-bit |
| plock_valid | input | 1 | Block lock request present |
| plock_mask | input | BLOCKS | One bit per user block to lock |
| resp_valid | output | 1 | Outcome pulse |
| resp_kind | output | 2 | 01 accept, 10 error, 11 silent |
| resp_err | output | 8 | Error byte, valid with ERROR |
| busy | output | 1 | Write sequence in progress |
| mem_we | output | 1 | Word write strobe |
| mem_bank | output | 2 | Bank of the word write |
| mem_addr | output | PTR_W | Word address of the write |
| mem_wdata | output | WORD_W | Word written |

## Verification
Suppose a request is sampled at a clock edge. Its outcome pulse and its first word write are both visible in the cycle that follows that edge. The second word of a pair is visible one cycle later, and busy is low again one cycle after that. The bench drives each request on a falling edge and then samples at the next three falling edges. At each of those three samples it compares the outcome, the write strobe, the address and the data against values it computes from the bank, pointer, count, profile and lock mask. A request raised while busy is high is sampled at the same points to confirm that no outcome and no extra write appear.

// File: rtl/mwg_pkg.sv
package mwg_pkg;

    typedef enum logic [1:0] {
        OUT_NONE   = 2'b00,
        OUT_ACCEPT = 2'b01,
        OUT_ERROR  = 2'b10,
        OUT_SILENT = 2'b11
    } outcome_e;

    typedef enum logic [1:0] {
        WS_IDLE   = 2'b00,
        WS_FIRST  = 2'b01,
        WS_SECOND = 2'b10
    } wr_state_e;

    typedef struct packed {
        outcome_e    kind;
        logic [7:0]  err;
        logic        pair;
    } verdict_t;

    localparam logic [1:0] BANK_USER   = 2'b11;
    localparam logic [7:0] ERR_GENERIC = 8'h00;
    localparam logic [7:0] ERR_LOCKED  = 8'h04;

    function automatic verdict_t judge(input logic zero, input logic one,
                                       input logic two, input logic odd,
                                       input logic locked);
        verdict_t v;
        v.kind = OUT_ACCEPT;
        v.err  = ERR_GENERIC;
        v.pair = two;
        if (zero) begin
            v.kind = OUT_SILENT;
            v.pair = 1'b0;
        end else if (!(one || two) || (two && odd)) begin
            v.kind = OUT_ERROR;
            v.pair = 1'b0;
        end else if (locked) begin
            v.kind = OUT_ERROR;
            v.err  = ERR_LOCKED;
            v.pair = 1'b0;
        end
        return v;
    endfunction

endpackage

// File: rtl/mwg_decide.sv
module mwg_decide
    import mwg_pkg::*;
#(
    parameter int PTR_W       = 8,
    parameter int CNT_W       = 8,
    parameter int BLOCKS      = 2,
    parameter int BLOCK_WORDS = 2
) (
    input  logic [1:0]        bank,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [CNT_W-1:0]  count,
    input  logic              wide,
    input  logic [BLOCKS-1:0] perm,
    output verdict_t          verdict
);
    localparam int AW = PTR_W + 1;

    logic [AW-1:0]     first_w;
    logic [AW-1:0]     last_w;
    logic [BLOCKS-1:0] hit;
    logic              is_two;

    assign is_two  = (count == CNT_W'(2));
    assign first_w = {1'b0, ptr};
    assign last_w  = first_w + (is_two ? AW'(1) : AW'(0));

    for (genvar b = 0; b < BLOCKS; b++) begin : g_blk
        localparam logic [AW-1:0] LO = AW'(b * BLOCK_WORDS);
        localparam logic [AW-1:0] HI = AW'(b * BLOCK_WORDS + BLOCK_WORDS - 1);
        assign hit[b] = perm[b] &&
                        (((first_w >= LO) && (first_w <= HI)) ||
                         ((last_w  >= LO) && (last_w  <= HI)));
    end

    always_comb begin
        verdict = judge(count == CNT_W'(0), count == CNT_W'(1), is_two,
                        ptr[0], (bank == BANK_USER) && wide && (|hit));
    end

endmodule

// File: rtl/mwg_lockreg.sv
module mwg_lockreg #(
    parameter int BLOCKS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_valid,
    input  logic [BLOCKS-1:0] set_mask,
    input  logic              wide,
    output logic [BLOCKS-1:0] perm
);
    always_ff @(posedge clk) begin
        if (rst) begin
            perm <= '0;
        end else if (set_valid && wide) begin
            perm <= perm | set_mask;
        end
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        ((perm & ~$past(perm)) != '1) |-> ((($past(perm) & ~perm)) == '0)); // R6

    AST_NARROW_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (set_valid && !wide) |=> (perm == $past(perm))); // R7

endmodule

// File: rtl/mwg_seq.sv
module mwg_seq
    import mwg_pkg::*;
#(
    parameter int PTR_W  = 8,
    parameter int WORD_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  verdict_t            verdict,
    input  logic [1:0]          req_bank,
    input  logic [PTR_W-1:0]    req_ptr,
    input  logic [2*WORD_W-1:0] req_wdata,
    output logic                resp_valid,
    output outcome_e            resp_kind,
    output logic [7:0]          resp_err,
    output logic                busy,
    output logic                mem_we,
    output logic [1:0]          mem_bank,
    output logic [PTR_W-1:0]    mem_addr,
    output logic [WORD_W-1:0]   mem_wdata
);
    wr_state_e             state;
    logic [PTR_W-1:0]      base_q;
    logic [1:0]            bank_q;
    logic [2*WORD_W-1:0]   data_q;
    logic                  pair_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= WS_IDLE;
            resp_valid <= 1'b0;
            resp_kind  <= OUT_NONE;
            resp_err   <= 8'h00;
            base_q     <= '0;
            bank_q     <= '0;
            data_q     <= '0;
            pair_q     <= 1'b0;
        end else begin
            resp_valid <= 1'b0;
            resp_kind  <= OUT_NONE;
            resp_err   <= 8'h00;
            unique case (state)
                WS_IDLE: begin
                    if (req_valid) begin
                        resp_valid <= 1'b1;
                        resp_kind  <= verdict.kind;
                        resp_err   <= verdict.err;
                        if (verdict.kind == OUT_ACCEPT) begin
                            state  <= WS_FIRST;
                            base_q <= req_ptr;
                            bank_q <= req_bank;
                            data_q <= req_wdata;
                            pair_q <= verdict.pair;
                        end
                    end
                end
                WS_FIRST:  state <= pair_q ? WS_SECOND : WS_IDLE;
                WS_SECOND: state <= WS_IDLE;
                default:   state <= WS_IDLE;
            endcase
        end
    end

    assign busy      = (state != WS_IDLE);
    assign mem_we    = busy;
    assign mem_bank  = bank_q;
    assign mem_addr  = base_q + ((state == WS_SECOND) ? PTR_W'(1) : PTR_W'(0));
    assign mem_wdata = (state == WS_SECOND) ? data_q[2*WORD_W-1:WORD_W]
                                            : data_q[WORD_W-1:0];

    AST_REFUSE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_kind != OUT_ACCEPT) |-> !mem_we); // R3

    AST_ACCEPT_WRITES: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_kind == OUT_ACCEPT) |-> (mem_we && mem_addr == $past(req_ptr))); // R8

    AST_PAIR_NEXT: assert property (@(posedge clk) disable iff (rst)
        (state == WS_FIRST && pair_q) |=> (mem_we && mem_addr == $past(mem_addr) + PTR_W'(1))); // R2

    AST_BUSY_NO_RESP: assert property (@(posedge clk) disable iff (rst)
        busy |=> !resp_valid); // R9

endmodule

// File: rtl/mw_write_gate.sv
module mw_write_gate
    import mwg_pkg::*;
#(
    parameter int PTR_W       = 8,
    parameter int CNT_W       = 8,
    parameter int WORD_W      = 16,
    parameter int BLOCKS      = 2,
    parameter int BLOCK_WORDS = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [1:0]          req_bank,
    input  logic [PTR_W-1:0]    req_ptr,
    input  logic [CNT_W-1:0]    req_count,
    input  logic [2*WORD_W-1:0] req_wdata,
    input  logic                user_wide,
    input  logic                plock_valid,
    input  logic [BLOCKS-1:0]   plock_mask,
    output logic                resp_valid,
    output logic [1:0]          resp_kind,
    output logic [7:0]          resp_err,
    output logic                busy,
    output logic                mem_we,
    output logic [1:0]          mem_bank,
    output logic [PTR_W-1:0]    mem_addr,
    output logic [WORD_W-1:0]   mem_wdata
);
    logic [BLOCKS-1:0] perm;
    verdict_t          verdict;
    outcome_e          kind_e;

    mwg_lockreg #(.BLOCKS(BLOCKS)) i_lock (
        .clk(clk), .rst(rst), .set_valid(plock_valid),
        .set_mask(plock_mask), .wide(user_wide), .perm(perm)
    );

    mwg_decide #(.PTR_W(PTR_W), .CNT_W(CNT_W), .BLOCKS(BLOCKS),
                 .BLOCK_WORDS(BLOCK_WORDS)) i_decide (
        .bank(req_bank), .ptr(req_ptr), .count(req_count),
        .wide(user_wide), .perm(perm), .verdict(verdict)
    );

    mwg_seq #(.PTR_W(PTR_W), .WORD_W(WORD_W)) i_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .verdict(verdict),
        .req_bank(req_bank), .req_ptr(req_ptr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_kind(kind_e), .resp_err(resp_err),
        .busy(busy), .mem_we(mem_we), .mem_bank(mem_bank),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    assign resp_kind = kind_e;

    AST_LOCKED_NOT_WRITTEN: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && req_bank == BANK_USER && user_wide &&
         req_ptr < PTR_W'(BLOCKS * BLOCK_WORDS) &&
         perm[req_ptr / PTR_W'(BLOCK_WORDS)]) |=> !mem_we); // R6

endmodule

// File: tb/test_mw_write_gate.sv
module test_mw_write_gate;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [7:0]  req_ptr = '0;
    logic [7:0]  req_count = '0;
    logic [31:0] req_wdata = '0;
    logic        user_wide = 1'b0;
    logic        plock_valid = 1'b0;
    logic [1:0]  plock_mask = '0;
    logic        resp_valid;
    logic [1:0]  resp_kind;
    logic [7:0]  resp_err;
    logic        busy;
    logic        mem_we;
    logic [1:0]  mem_bank;
    logic [7:0]  mem_addr;
    logic [15:0] mem_wdata;

    int checks = 0;
    int failures = 0;
    logic [1:0] lk_model = 2'b00;

    always #10 clk = ~clk;

    mw_write_gate i_mw_write_gate (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_bank(req_bank),
        .req_ptr(req_ptr), .req_count(req_count), .req_wdata(req_wdata),
        .user_wide(user_wide), .plock_valid(plock_valid), .plock_mask(plock_mask),
        .resp_valid(resp_valid), .resp_kind(resp_kind), .resp_err(resp_err),
        .busy(busy), .mem_we(mem_we), .mem_bank(mem_bank), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic lock_req(input logic [1:0] m);
        @(negedge clk);
        plock_valid = 1'b1;
        plock_mask  = m;
        @(negedge clk);
        plock_valid = 1'b0;
        if (user_wide) lk_model = lk_model | m;
    endtask

    task automatic run_req(input logic [1:0] b, input int p, input int c,
                           input string force_tag);
        logic [1:0] ekind;
        logic [7:0] eerr;
        int nw;
        bit locked;
        string tag;
        logic [31:0] d;
        d = {8'hA5, 8'(p), 6'(c), b, 8'h3C} ^ {16'h1234, 16'hC0DE};
        locked = (b == 2'b11) && user_wide &&
                 ((p < 4 && lk_model[p/2]) || (c == 2 && p + 1 < 4 && lk_model[(p+1)/2]));
        nw = 0; eerr = 8'h00;
        if (c == 0)                   begin ekind = 2'b11; tag = "R5"; end
        else if (c > 2)               begin ekind = 2'b10; tag = "R4"; end
        else if (c == 2 && (p % 2))   begin ekind = 2'b10; tag = "R3"; end
        else if (locked)              begin ekind = 2'b10; eerr = 8'h04; tag = "R6"; end
        else begin ekind = 2'b01; nw = c; tag = (c == 1) ? "R1" : "R2"; end
        if (force_tag != "") tag = force_tag;
        @(negedge clk);
        req_valid = 1'b1; req_bank = b; req_ptr = 8'(p);
        req_count = 8'(c); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk(resp_valid == 1'b1, "R8 outcome pulse", 32'(resp_valid), 1);
        chk(resp_kind == ekind && resp_err == eerr, tag,
            {22'd0, resp_kind, resp_err}, {22'd0, ekind, eerr});
        chk(mem_we == (nw >= 1), tag, 32'(mem_we), 32'(nw >= 1));
        if (nw >= 1)
            chk(mem_addr == 8'(p) && mem_bank == b && mem_wdata == d[15:0], tag,
                {6'd0, mem_bank, mem_addr, mem_wdata}, {6'd0, b, 8'(p), d[15:0]});
        @(negedge clk);
        chk(resp_valid == 1'b0, "R8 single cycle", 32'(resp_valid), 0);
        chk(mem_we == (nw == 2), tag, 32'(mem_we), 32'(nw == 2));
        if (nw == 2)
            chk(mem_addr == 8'(p + 1) && busy && mem_wdata == d[31:16], "R2",
                {7'd0, busy, mem_addr, mem_wdata}, {7'd0, 1'b1, 8'(p + 1), d[31:16]});
        if (nw == 2) @(negedge clk);
        chk(!busy && !mem_we, tag, {30'd0, busy, mem_we}, 0);
    endtask

    task automatic sweep();
        for (int b = 0; b < 4; b++)
            for (int p = 0; p < 6; p++)
                for (int c = 0; c < 4; c++)
                    run_req(2'(b), p, c, "");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!resp_valid && !mem_we && !busy, "R10 reset outputs",
            {29'd0, resp_valid, mem_we, busy}, 0);
        user_wide = 1'b1;
        run_req(2'b11, 0, 2, "R10 no lock after reset");
        user_wide = 1'b0;

        sweep();
        lock_req(2'b11);
        user_wide = 1'b1;
        run_req(2'b11, 0, 2, "R7");
        run_req(2'b11, 2, 2, "R7");
        sweep();
        lock_req(2'b01);
        sweep();
        lock_req(2'b10);
        sweep();

        // R9: request raised while the second word of a pair is in flight
        @(negedge clk);
        req_valid = 1'b1; req_bank = 2'b00; req_ptr = 8'd4;
        req_count = 8'd2; req_wdata = 32'hBEEF_CAFE;
        @(negedge clk);
        req_ptr = 8'd7; req_count = 8'd1; req_wdata = 32'h0000_1111;
        chk(resp_valid && mem_addr == 8'd4, "R9 first accepted",
            {23'd0, resp_valid, mem_addr}, {23'd0, 1'b1, 8'd4});
        @(negedge clk);
        req_valid = 1'b0;
        chk(!resp_valid && mem_addr == 8'd5 && mem_wdata == 16'hBEEF, "R9 busy request ignored",
            {7'd0, resp_valid, mem_addr, mem_wdata}, {8'd0, 8'd5, 16'hBEEF});
        @(negedge clk);
        chk(!resp_valid && !mem_we && !busy, "R9 no late outcome",
            {29'd0, resp_valid, mem_we, busy}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule